// File: doc/BRIEF.md
# Peripheral clock mux-divide-gate chain

This block derives one peripheral clock from a set of reference clocks. A selector picks one reference, two cascaded integer dividers slow it down by the product of their settings, and a final gate can stop the result. The settings live in a small register file on a simple write-strobe bus with a combinational read port. The references are expected to be square waves that are synchronous to the system clock `clk`, with every high and low phase lasting at least two `clk` cycles. The block samples them and counts both of their edges, so `clk_out` is a registered waveform in the `clk` domain.

A divider code of zero or all ones cannot be used. Such a code raises `div_bad` and parks the output low. New select and divider settings are adopted only when the chain is idle with its output low, and changes to the gate are adopted only while the divided clock is low. The output therefore never shows a shortened pulse. A second build variant takes a fixed parent (reference 0) and a single divider with a one-bit code looked up as divide-by-2 or divide-by-4. Several copies can share one register space because each copy places its fields through parameters.

Top module: `perclk_chain`

## Requirements
- R1: During and after reset `clk_out` and `div_bad` are 0. The select field resets to 0, both divider codes reset to 1 (table variant: code 0) and the gate-disable bit resets to 0.
- R2: Register layout with the default parameters: select at address 0x00 bits [3:2], divider A at address 0x04 bits [10:8], divider B at address 0x08 bits [6:4], gate-disable at address 0x14 bit 5. Unowned bits read as 0, and writes to other addresses or bits change nothing.
- R3: Select code k (0..3) makes `ref_clk[k]` the only reference that drives the divider chain.
- R4: With valid codes A and B, `clk_out` toggles once every A·B edges (rising and falling) of the selected reference, so its period is exactly A·B reference periods.
- R5: With A = B = 1, `clk_out` follows the selected reference one `clk` cycle late.
- R6: A divider code of 0 or 7 sets `div_bad` in the cycle after the write and stops `clk_out` low. Writing valid codes clears the flag and restarts the clock.
- R7: A new select or divider setting takes effect only when the chain is idle with the output low and no reference edge is pending. An output phase that is already running keeps the length the old setting gives it.
- R8: Gate-disable = 1 holds `clk_out` low and 0 lets it run. A change in the bit is adopted only while the divided clock is low, so no pulse is cut short.
- R9: The table variant uses `ref_clk[0]` whatever the select register holds. Its one-bit code (default address 0x0C bit 1, gate bit 9) gives divide-by-2 for 0 and divide-by-4 for 1, and never sets `div_bad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; references are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | N_REF | Reference clocks, synchronous to `clk` |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| clk_out | output | 1 | Divided and gated peripheral clock |
| div_bad | output | 1 | A programmed divider code is unusable |

## Verification
On every cycle the assertions check that a rise of the output always follows an edge of the selected reference. They also check that the active select and the gate change only while the divided clock is low, and that an unusable active setting keeps the output low. Exact periods for each ratio, the defer-until-idle behaviour when settings are rewritten mid-phase, the register layout and the fixed parent of the table variant can only be shown by the bench. Its edge-counting reference model is compared with both outputs of both variants on every clock.

// File: rtl/perclk_pkg.sv
// Shared definitions for the peripheral clock chain.
// Assumes nothing beyond the parameters of the instantiating block.
package perclk_pkg;

    // Build variant: full selector plus two dividers, or fixed parent with table divider
    typedef enum logic [0:0] {
        MODE_FULL  = 1'b0,
        MODE_TABLE = 1'b1
    } perclk_mode_e;

    // Register addresses that every instance decodes at the same place
    localparam int SEL_ADDR  = 'h00;
    localparam int GATE_ADDR = 'h14;

    // Number of cascaded divider stages
    localparam int N_STAGE = 2;

endpackage

// File: rtl/perclk_regs.sv
// Settings register file for one clock chain.
// Stores only the fields this instance owns; each field's address and bit
// position come from parameters so several instances can share one map.
// Assumes single-cycle writes and a combinational read.
module perclk_regs #(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 32,
    parameter int SEL_W     = 2,
    parameter int DIV_W     = 3,
    parameter int A_W       = 3,
    parameter bit HAS_SEL   = 1'b1,
    parameter bit HAS_B     = 1'b1,
    parameter int SEL_POS   = 2,
    parameter int A_ADDR    = 'h04,
    parameter int A_POS     = 8,
    parameter int A_RST     = 1,
    parameter int B_ADDR    = 'h08,
    parameter int B_POS     = 4,
    parameter int GATE_POS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [SEL_W-1:0]  cfg_sel,
    output logic [A_W-1:0]    cfg_a,
    output logic [DIV_W-1:0]  cfg_b,
    output logic              cfg_dis
);
    import perclk_pkg::*;

    localparam logic [ADDR_W-1:0] SEL_AD  = ADDR_W'(SEL_ADDR);
    localparam logic [ADDR_W-1:0] A_AD    = ADDR_W'(A_ADDR);
    localparam logic [ADDR_W-1:0] B_AD    = ADDR_W'(B_ADDR);
    localparam logic [ADDR_W-1:0] GATE_AD = ADDR_W'(GATE_ADDR);

    logic hit_sel, hit_a, hit_b, hit_gate;

    // Address decode for writes and reads
    always_comb begin
        hit_sel  = HAS_SEL && (bus_addr == SEL_AD);
        hit_a    = (bus_addr == A_AD);
        hit_b    = HAS_B && (bus_addr == B_AD);
        hit_gate = (bus_addr == GATE_AD);
    end

    generate
        if (HAS_SEL) begin : g_sel
            // Select field storage
            always_ff @(posedge clk) begin
                if (!rst_n)                cfg_sel <= '0;
                else if (bus_wr && hit_sel) cfg_sel <= bus_wdata[SEL_POS +: SEL_W];
            end
        end else begin : g_no_sel
            assign cfg_sel = '0;
        end

        if (HAS_B) begin : g_b
            // Second divider field storage
            always_ff @(posedge clk) begin
                if (!rst_n)              cfg_b <= DIV_W'(1);
                else if (bus_wr && hit_b) cfg_b <= bus_wdata[B_POS +: DIV_W];
            end
        end else begin : g_no_b
            assign cfg_b = DIV_W'(1);
        end
    endgenerate

    // First divider field storage
    always_ff @(posedge clk) begin
        if (!rst_n)              cfg_a <= A_W'(A_RST);
        else if (bus_wr && hit_a) cfg_a <= bus_wdata[A_POS +: A_W];
    end

    // Gate-disable bit storage
    always_ff @(posedge clk) begin
        if (!rst_n)                 cfg_dis <= 1'b0;
        else if (bus_wr && hit_gate) cfg_dis <= bus_wdata[GATE_POS];
    end

    // Read mux: owned fields in place, all other bits zero
    always_comb begin
        bus_rdata = '0;
        if (hit_sel)  bus_rdata[SEL_POS +: SEL_W] = cfg_sel;
        if (hit_a)    bus_rdata[A_POS +: A_W]     = cfg_a;
        if (hit_b)    bus_rdata[B_POS +: DIV_W]   = bus_rdata[B_POS +: DIV_W] | cfg_b;
        if (hit_gate) bus_rdata[GATE_POS]         = cfg_dis;
    end

    // Write-data bits outside the owned fields are intentionally dropped
    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/perclk_edge.sv
// Reference sampler and selector.
// Registers every reference each cycle and reports a level change on the
// selected one. Per-reference history means a select change never fakes an edge.
// Assumes references are synchronous to clk with phases of two cycles or more.
module perclk_edge #(
    parameter int N_REF = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REF-1:0] ref_clk,
    input  logic [SEL_W-1:0] sel,
    output logic             sel_edge
);
    logic [N_REF-1:0] ref_q;
    logic [N_REF-1:0] chg;

    // Sample history of all references
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= '0;
        else        ref_q <= ref_clk;
    end

    // Level change per reference, then pick the active one
    always_comb begin
        chg      = ref_clk ^ ref_q;
        sel_edge = chg[sel];
    end

endmodule

// File: rtl/perclk_stage.sv
// One integer divider stage.
// Counts input ticks and toggles its level every RATIO ticks; reports the
// tick on which it toggles so a following stage can count it. Hold clears it.
// Assumes ratio is non-zero whenever hold is low.
module perclk_stage #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             tick,
    input  logic [CNT_W-1:0] ratio,
    output logic             level,
    output logic             wrap,
    output logic             idle
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Terminal count and toggle strobe
    always_comb begin
        last = ratio - CNT_W'(1);
        wrap = tick && !hold && (cnt == last);
        idle = (cnt == '0) && !level;
    end

    // Tick counter and output level
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt   <= '0;
            level <= 1'b0;
        end else if (tick) begin
            if (cnt == last) begin
                cnt   <= '0;
                level <= ~level;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/perclk_chain.sv
// Peripheral clock chain: reference select, two cascaded dividers, gate.
// Programmed settings are copied into an active set only while the divider
// chain is idle with its output low; the gate follows its bit only while the
// divided clock is low. Assumes references synchronous to clk with phases of
// at least two clk cycles.
module perclk_chain
    import perclk_pkg::*;
#(
    parameter perclk_mode_e MODE     = MODE_FULL,
    parameter int           N_REF    = 4,
    parameter int           DIV_W    = 3,
    parameter int           ADDR_W   = 5,
    parameter int           DATA_W   = 32,
    parameter int           SEL_POS  = 2,
    parameter int           A_ADDR   = 'h04,
    parameter int           A_POS    = 8,
    parameter int           B_ADDR   = 'h08,
    parameter int           B_POS    = 4,
    parameter int           GATE_POS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REF-1:0]  ref_clk,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              clk_out,
    output logic              div_bad
);
    localparam bit IS_FULL = (MODE == MODE_FULL);
    localparam int SEL_W   = (N_REF > 1) ? $clog2(N_REF) : 1;
    localparam int A_W     = IS_FULL ? DIV_W : 1;
    localparam int A_RST   = IS_FULL ? 1 : 0;
    localparam logic [DIV_W-1:0] RST_R0 = IS_FULL ? DIV_W'(1) : DIV_W'(2);

    logic [SEL_W-1:0] cfg_sel;
    logic [A_W-1:0]   cfg_a;
    logic [DIV_W-1:0] cfg_b;
    logic             cfg_dis;

    logic [SEL_W-1:0] prog_sel;
    logic [DIV_W-1:0] prog_r [N_STAGE];
    logic             prog_bad;

    logic [SEL_W-1:0] act_sel;
    logic [DIV_W-1:0] act_r [N_STAGE];
    logic             act_bad;

    logic             sel_edge;
    logic [N_STAGE:0] tick;
    logic [N_STAGE-1:0] lvl, idle;
    logic             div_lvl;
    logic             all_idle;
    logic             load;
    logic             gate_on;

    perclk_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .DIV_W(DIV_W),
        .A_W(A_W), .HAS_SEL(IS_FULL), .HAS_B(IS_FULL), .SEL_POS(SEL_POS),
        .A_ADDR(A_ADDR), .A_POS(A_POS), .A_RST(A_RST), .B_ADDR(B_ADDR),
        .B_POS(B_POS), .GATE_POS(GATE_POS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_sel(cfg_sel),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_dis(cfg_dis)
    );

    generate
        if (IS_FULL) begin : g_full
            // Raw codes are ratios; zero and all-ones codes are unusable
            always_comb begin
                prog_sel  = cfg_sel;
                prog_r[0] = DIV_W'(cfg_a);
                prog_r[1] = cfg_b;
                prog_bad  = (cfg_a == '0) || (cfg_a == '1) ||
                            (cfg_b == '0) || (cfg_b == '1);
            end
        end else begin : g_table
            // Fixed parent; one-bit code looked up as divide-by-2 or by-4
            always_comb begin
                prog_sel  = '0;
                prog_r[0] = cfg_a[0] ? DIV_W'(4) : DIV_W'(2);
                prog_r[1] = DIV_W'(1);
                prog_bad  = 1'b0;
            end
            logic unused_cfg;
            assign unused_cfg = ^{cfg_sel, cfg_b};
        end
    endgenerate

    perclk_edge #(
        .N_REF(N_REF), .SEL_W(SEL_W)
    ) u_edge (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .sel(act_sel),
        .sel_edge(sel_edge)
    );

    assign tick[0] = sel_edge;

    generate
        for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
            perclk_stage #(
                .CNT_W(DIV_W)
            ) u_stage (
                .clk(clk), .rst_n(rst_n), .hold(act_bad), .tick(tick[s]),
                .ratio(act_r[s]), .level(lvl[s]), .wrap(tick[s+1]),
                .idle(idle[s])
            );
        end
    endgenerate

    // Chain state summary used for deferred updates
    always_comb begin
        div_lvl  = lvl[N_STAGE-1];
        all_idle = &idle;
        load     = all_idle && !sel_edge;
    end

    // Active settings: adopted only at an idle, low, edge-free cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel  <= '0;
            act_r[0] <= RST_R0;
            act_r[1] <= DIV_W'(1);
            act_bad  <= 1'b0;
        end else if (load) begin
            act_sel  <= prog_sel;
            act_r[0] <= prog_r[0];
            act_r[1] <= prog_r[1];
            act_bad  <= prog_bad;
        end
    end

    // Gate enable follows the disable bit only while the divided clock is low
    always_ff @(posedge clk) begin
        if (!rst_n)        gate_on <= 1'b1;
        else if (!div_lvl) gate_on <= ~cfg_dis;
    end

    // Output drive and status
    always_comb begin
        clk_out = div_lvl & gate_on;
        div_bad = prog_bad;
    end

    logic unused_tick;
    assign unused_tick = tick[N_STAGE];

endmodule

// File: rtl/perclk_chain_chk.sv
// Property checker for perclk_chain, attached with bind.
// Observes the output, active settings, gate state and the selected edge.
module perclk_chain_chk #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_out,
    input logic [SEL_W-1:0] act_sel,
    input logic             act_bad,
    input logic             div_lvl,
    input logic             gate_on,
    input logic             sel_edge
);
    // R4: the output can only rise after an edge of the selected reference
    a_r4_rise_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out) |-> $past(sel_edge));

    // R6: an unusable active setting keeps the output parked low
    a_r6_bad_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
        act_bad |-> !clk_out);

    // R7: the active select changes only after a low divided-clock cycle
    a_r7_sel_change_low: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sel != $past(act_sel)) |-> !$past(div_lvl));

    // R8: the gate state changes only after a low divided-clock cycle
    a_r8_gate_change_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gate_on) |-> !$past(div_lvl));

endmodule

bind perclk_chain perclk_chain_chk #(.SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_out(clk_out), .act_sel(act_sel),
    .act_bad(act_bad), .div_lvl(div_lvl), .gate_on(gate_on),
    .sel_edge(sel_edge)
);

// File: tb/perclk_chain_bench.sv
`timescale 1ns/1ps
module perclk_chain_bench;
    import perclk_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ref_clk = 4'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd0, rd1;
    logic [1:0]  outs, bads;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    perclk_chain u_perclk_chain (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd0),
        .clk_out(outs[0]), .div_bad(bads[0])
    );

    perclk_chain #(
        .MODE(MODE_TABLE), .A_ADDR('h0C), .A_POS(1), .GATE_POS(9)
    ) u_perclk_chain_tbl (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd1),
        .clk_out(outs[1]), .div_bad(bads[1])
    );

    // Reference generators: half periods in clk cycles
    int hp [4] = '{3, 4, 5, 7};
    int rc [4] = '{0, 0, 0, 0};
    always @(negedge clk) begin
        for (int k = 0; k < 4; k++) begin
            rc[k]++;
            if (rc[k] >= hp[k]) begin
                rc[k] = 0;
                ref_clk[k] = ~ref_clk[k];
            end
        end
    end

    // Behavioural model: programmed fields, active ratio, edge count
    int m_sel, m_a, m_b, m_code;
    int m_dis [2];
    int k_sel;
    int k_ratio [2];
    bit k_bad [2];
    int e [2];
    bit lvl [2], gon [2];
    bit [3:0] rprev;
    bit exp_out [2], exp_bad [2];

    function automatic int ratio0();
        int fa, fb;
        fa = (m_a == 7) ? 0 : m_a;
        fb = (m_b == 7) ? 0 : m_b;
        return fa * fb;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_a = 1; m_b = 1; m_code = 0;
            k_sel = 0; k_ratio[0] = 1; k_ratio[1] = 2;
            rprev = '0;
            for (int i = 0; i < 2; i++) begin
                m_dis[i] = 0; k_bad[i] = 0; e[i] = 0; lvl[i] = 0; gon[i] = 1;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                int src;
                bit edg, zero, old;
                src  = (i == 0) ? k_sel : 0;
                edg  = (ref_clk[src] != rprev[src]);
                zero = (e[i] == 0) && !lvl[i];
                old  = lvl[i];
                if (k_bad[i]) begin
                    e[i] = 0; lvl[i] = 0;
                end else if (edg) begin
                    e[i]++;
                    if (e[i] >= k_ratio[i]) begin
                        e[i] = 0; lvl[i] = !lvl[i];
                    end
                end
                if (!old) gon[i] = (m_dis[i] == 0);
                if (zero && !edg) begin
                    if (i == 0) begin
                        k_sel = m_sel; k_ratio[0] = ratio0();
                    end else begin
                        k_ratio[1] = (m_code != 0) ? 4 : 2;
                    end
                    k_bad[i] = (k_ratio[i] == 0);
                end
            end
            if (bus_wr) begin
                case (bus_addr)
                    5'h00: m_sel  = (bus_wdata >> 2) & 3;
                    5'h04: m_a    = (bus_wdata >> 8) & 7;
                    5'h08: m_b    = (bus_wdata >> 4) & 7;
                    5'h0C: m_code = (bus_wdata >> 1) & 1;
                    5'h14: begin
                        m_dis[0] = (bus_wdata >> 5) & 1;
                        m_dis[1] = (bus_wdata >> 9) & 1;
                    end
                    default: ;
                endcase
            end
            rprev = ref_clk;
        end
        for (int i = 0; i < 2; i++) exp_out[i] = lvl[i] & gon[i];
        exp_bad[0] = (ratio0() == 0);
        exp_bad[1] = 0;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of both variants against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "clk_out full", 32'(outs[0]), 32'(exp_out[0]));
            chk(cur_req, "div_bad full", 32'(bads[0]), 32'(exp_bad[0]));
            chk("R9", "clk_out table", 32'(outs[1]), 32'(exp_out[1]));
            chk("R9", "div_bad table", 32'(bads[1]), 32'(exp_bad[1]));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] a,
                      input logic [31:0] e0, input logic [31:0] e1);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, "rdata full", rd0, e0);
        chk(req, "rdata table", rd1, e1);
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "clk_out in reset", 32'(outs[0]), 0);
        chk("R1", "div_bad in reset", 32'(bads[0]), 0);
        chk("R1", "table clk_out in reset", 32'(outs[1]), 0);
        @(negedge clk);
        rst_n = 1'b1;
        rd("R1", 5'h00, 32'h0, 32'h0);
        rd("R1", 5'h04, 32'h100, 32'h0);
        rd("R1", 5'h08, 32'h10, 32'h0);
        rd("R1", 5'h0C, 32'h0, 32'h0);
        rd("R1", 5'h14, 32'h0, 32'h0);

        // R5: ratio one follows reference 0
        cur_req = "R5";
        run(80);

        // R3: each reference in turn
        cur_req = "R3";
        for (int s = 1; s < 4; s++) begin
            wr(5'h00, 32'(s) << 2);
            run(200);
        end
        wr(5'h00, 32'h0);

        // R4: several ratio pairs
        cur_req = "R4";
        wr(5'h04, 32'h200); wr(5'h08, 32'h30); run(400);
        wr(5'h04, 32'h300); wr(5'h08, 32'h10); run(300);
        wr(5'h04, 32'h400); wr(5'h08, 32'h20); run(500);
        wr(5'h04, 32'h600); wr(5'h08, 32'h60); run(700);
        wr(5'h00, 32'hC);
        wr(5'h04, 32'h500); wr(5'h08, 32'h50); run(1000);

        // R7: rewrite settings while the output is high
        cur_req = "R7";
        wr(5'h00, 32'h0); wr(5'h04, 32'h300); wr(5'h08, 32'h20);
        run(120);
        while (!outs[0]) @(negedge clk);
        wr(5'h04, 32'h100); wr(5'h08, 32'h10);
        run(150);
        wr(5'h04, 32'h400);
        while (!outs[0]) @(negedge clk);
        wr(5'h00, 32'h8); wr(5'h04, 32'h200);
        run(300);

        // R6: unusable codes stop the clock and raise the flag
        cur_req = "R6";
        wr(5'h04, 32'h700);
        chk("R6", "flag after code 7", 32'(bads[0]), 1);
        run(300);
        chk("R6", "output parked low", 32'(outs[0]), 0);
        wr(5'h04, 32'h000);
        chk("R6", "flag after code 0", 32'(bads[0]), 1);
        wr(5'h04, 32'h200); wr(5'h08, 32'h70);
        chk("R6", "flag after B code 7", 32'(bads[0]), 1);
        wr(5'h08, 32'h30);
        chk("R6", "flag cleared", 32'(bads[0]), 0);
        run(300);

        // R8: gate disable on each instance
        cur_req = "R8";
        wr(5'h14, 32'h20); run(300);
        chk("R8", "gated output low", 32'(outs[0]), 0);
        wr(5'h14, 32'h200); run(300);
        wr(5'h14, 32'h0); run(300);

        // R2: layout, unowned bits and unrelated addresses
        cur_req = "R2";
        wr(5'h00, 32'hFFFF_FFFF);
        rd("R2", 5'h00, 32'hC, 32'h0);
        wr(5'h10, 32'hFFFF_FFFF);
        rd("R2", 5'h04, 32'h200, 32'h0);
        rd("R2", 5'h08, 32'h30, 32'h0);
        rd("R2", 5'h14, 32'h0, 32'h0);
        run(200);

        // R9: table codes while the select register points elsewhere
        cur_req = "R4";
        wr(5'h0C, 32'h2);
        rd("R9", 5'h0C, 32'h0, 32'h2);
        run(400);
        wr(5'h0C, 32'h0);
        run(300);

        done = 1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule